// File: doc/BRIEF.md
# Staged Module Power-State Sequencer

This block is a small memory-mapped controller that places up to 32 modules in a power state each: clock gated or running, reset held or released. Software writes a requested state code into one register per module. These writes are only staged. The outputs do not change until software issues a global go command. After the go, the block walks through every module whose requested state differs from its present state. It handles them one at a time, in ascending index order, and spends a fixed number of clock cycles on each.

A busy flag in the status register stays high for as long as the walk runs. Software is expected to poll that flag until it reads idle, both before and after each go. A go that arrives while the walk is running is dropped. A read-only register per module returns the state that module currently has. The block decodes that present state into a clock-enable output and a reset-release output for each module.

Top module: `pd_seq_ctrl`

## Requirements
- R1: After reset, every requested-state and present-state field reads 0, the status register reads 0, and every clock-enable and reset-release output is 0.
- R2: The requested-state register of module n sits at byte address 0xA00 + 4n. A write stores bits 4:0 of the write data. A read returns the stored 5-bit code with bits 31:5 reading 0.
- R3: The present state of module n reads back in bits 4:0 at byte address 0x800 + 4n, with the other bits 0.
- R4: Present-state code 3 gives clock on and reset released. Code 1 gives clock on and reset held. Code 2 gives clock off and reset released. Code 0 and every code from 4 to 31 give clock off and reset held.
- R5: Writing a requested-state register changes neither the outputs nor any present state until a go command is accepted.
- R6: A write to address 0x120 with data bit 0 equal to 1 while idle starts a walk if at least one module is pending, meaning its requested code differs from its present code. Bit 0 of the status register at 0x128 reads 1 from the cycle after that write. The pending modules take their requested codes in ascending index order. The pending module of rank r (counting from 0) changes on the 4·(r+1)-th clock edge after the go edge. The status bit returns to 0 on the edge where the last pending module changes.
- R7: A go command while no module is pending leaves the status bit at 0 and changes nothing.
- R8: A go command that arrives while the status bit reads 1 is ignored. The walk applies the codes captured at the accepted go, and requests written during the walk take effect only at the next accepted go.
- R9: A write to address 0x120 with data bit 0 equal to 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| mod_clk_en | output | 32 | Per-module clock enable |
| mod_rst_rel | output | 32 | Per-module reset release (1 = out of reset) |

## Verification
In the first pattern, module i is given code i, so one walk covers all 32 codes. This separates the four decoded behaviours from the decode of the unused codes, and it exercises a 31-step walk in which the bench predicts every output bit on every edge. A scrambled second pattern receives a new request and a go in the middle of its walk, which shows whether the block captured its targets at the accepted go or reads the live request registers. A sparse pattern that touches only the first and last modules checks the ascending order and the step spacing when the pending modules are far apart. A go with nothing pending and a command write with bit 0 clear are both checked to leave the status bit and all outputs unchanged.

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl #(
  parameter int N_MOD    = 32,
  parameter int STEP_CYC = 4,
  parameter int AW       = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_MOD-1:0]  mod_clk_en,
  output logic [N_MOD-1:0]  mod_rst_rel
);
  localparam int IW     = (N_MOD > 1) ? $clog2(N_MOD) : 1;
  localparam int CW     = $clog2(STEP_CYC + 1);
  localparam int A_CMD  = 'h120;
  localparam int A_STAT = 'h128;
  localparam int A_CUR  = 'h800;
  localparam int A_NEXT = 'hA00;

  logic [4:0]       nxt [N_MOD];
  logic [4:0]       cur [N_MOD];
  logic [4:0]       tgt [N_MOD];
  logic [N_MOD-1:0] mask, pend, rest;
  logic             busy;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    sel;

  int addr_i;
  assign addr_i = int'(bus_addr);

  logic in_next, in_cur;
  logic [IW-1:0] nidx, cidx;
  assign in_next = addr_i >= A_NEXT && addr_i < A_NEXT + 4*N_MOD && bus_addr[1:0] == 2'b00;
  assign in_cur  = addr_i >= A_CUR  && addr_i < A_CUR  + 4*N_MOD && bus_addr[1:0] == 2'b00;
  assign nidx = IW'((addr_i - A_NEXT) >> 2);
  assign cidx = IW'((addr_i - A_CUR) >> 2);

  logic go, start, step_done;
  assign go        = bus_wr && addr_i == A_CMD && bus_wdata[0];
  assign start     = go && !busy && |pend;
  assign step_done = busy && cnt == CW'(STEP_CYC - 1);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:5];

  generate
    for (genvar g = 0; g < N_MOD; g++) begin : g_mod
      assign pend[g]        = nxt[g] != cur[g];
      assign mod_clk_en[g]  = cur[g] == 5'd3 || cur[g] == 5'd1;
      assign mod_rst_rel[g] = cur[g] == 5'd3 || cur[g] == 5'd2;
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = N_MOD - 1; i >= 0; i--)
      if (mask[i]) sel = IW'(i);
  end

  assign rest = mask & ~({{(N_MOD-1){1'b0}}, 1'b1} << sel);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < N_MOD; i++) nxt[i] <= '0;
    end else if (bus_wr && in_next) begin
      nxt[nidx] <= bus_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      mask <= '0;
      for (int i = 0; i < N_MOD; i++) begin
        cur[i] <= '0;
        tgt[i] <= '0;
      end
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      mask <= pend;
      for (int i = 0; i < N_MOD; i++) tgt[i] <= nxt[i];
    end else if (busy) begin
      if (step_done) begin
        cnt       <= '0;
        cur[sel]  <= tgt[sel];
        mask      <= rest;
        if (rest == '0) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_i == A_STAT)  bus_rdata[0]   = busy;
    else if (in_next)      bus_rdata[4:0] = nxt[nidx];
    else if (in_cur)       bus_rdata[4:0] = cur[cidx];
  end

  p_idle_outputs_hold_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !busy |=> ($stable(mod_clk_en) && $stable(mod_rst_rel)));

  p_busy_has_work_r6: assert property (@(posedge clk) disable iff (!arst_n)
    busy |-> mask != '0);

  p_one_module_per_edge_r6: assert property (@(posedge clk) disable iff (!arst_n)
    $countones((mod_clk_en ^ $past(mod_clk_en)) | (mod_rst_rel ^ $past(mod_rst_rel))) <= 1);

  p_step_count_bound_r6: assert property (@(posedge clk) disable iff (!arst_n)
    int'(cnt) < STEP_CYC);

  p_no_new_work_busy_r8: assert property (@(posedge clk) disable iff (!arst_n)
    busy |=> (mask & ~$past(mask)) == '0);

  p_clear_bit_no_start_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (!busy && bus_wr && addr_i == A_CMD && !bus_wdata[0]) |=> !busy);
endmodule

// File: tb/pd_seq_ctrl_test.sv
module pd_seq_ctrl_test;
  localparam int N = 32;
  logic clk = 1'b0, arst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [N-1:0] ce, rel;
  int errors = 0, checks = 0, k = 0;
  int nxt_m[N], cur_m[N], tgt_m[N], pl[N];

  pd_seq_ctrl uut (.clk(clk), .arst_n(arst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                   .mod_clk_en(ce), .mod_rst_rel(rel));

  always #10 clk = ~clk;

  function automatic logic [N-1:0] exp_ce();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = cur_m[i] == 3 || cur_m[i] == 1;
    return v;
  endfunction

  function automatic logic [N-1:0] exp_rel();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = cur_m[i] == 3 || cur_m[i] == 2;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_next(input int i, input int code);
    wr(12'(32'hA00 + 4 * i), 32'(code));
    nxt_m[i] = code & 31;
  endtask

  task automatic check_outputs(input string req);
    chk(req, "clk_en", ce, exp_ce());
    chk(req, "rst_rel", rel, exp_rel());
  endtask

  task automatic run_go(input bit inject, input int im, input int ic);
    logic [31:0] d;
    k = 0;
    for (int i = 0; i < N; i++) begin
      tgt_m[i] = nxt_m[i];
      if (nxt_m[i] != cur_m[i]) begin pl[k] = i; k++; end
    end
    wr(12'h120, 32'h1);
    rd(12'h128, d);
    chk("R6", "status after go", d, 32'(k > 0));
    check_outputs("R6");
    for (int t = 1; t <= 4 * k; t++) begin
      if (inject && t == 1) begin
        bus_wr = 1'b1; bus_addr = 12'(32'hA00 + 4 * im); bus_wdata = 32'(ic);
      end else if (inject && t == 2) begin
        bus_wr = 1'b1; bus_addr = 12'h120; bus_wdata = 32'h1;
      end
      @(negedge clk);
      bus_wr = 1'b0;
      if (inject && t == 1) nxt_m[im] = ic;
      if (t % 4 == 0) cur_m[pl[t/4-1]] = tgt_m[pl[t/4-1]];
      check_outputs(inject ? "R8" : "R6");
      rd(12'h128, d);
      chk("R6", "status during walk", d, 32'(t < 4 * k));
    end
  endtask

  task automatic check_readback();
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      rd(12'(32'h800 + 4 * i), d);
      chk("R3", "present state", d, 32'(cur_m[i]));
      rd(12'(32'hA00 + 4 * i), d);
      chk("R2", "requested state", d, 32'(nxt_m[i]));
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R6 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin nxt_m[i] = 0; cur_m[i] = 0; end
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);
    rd(12'h128, d);
    chk("R1", "status after reset", d, 32'h0);
    check_outputs("R1");
    check_readback();

    // R2: upper write bits dropped
    set_next(4, 32'hFFFF_FFE5);
    rd(12'hA10, d);
    chk("R2", "masked code", d, 32'h5);

    // Pattern A: module i requests code i, covering every code
    for (int i = 0; i < N; i++) set_next(i, i);
    repeat (3) @(negedge clk);
    check_outputs("R5");
    rd(12'h804, d);
    chk("R5", "present unchanged before go", d, 32'h0);
    // R9: command write with bit 0 clear starts nothing
    wr(12'h120, 32'hFFFF_FFFE);
    rd(12'h128, d);
    chk("R9", "status after clear-bit command", d, 32'h0);
    repeat (2) @(negedge clk);
    check_outputs("R9");
    run_go(1'b0, 0, 0);
    check_readback();
    for (int c = 0; c < N; c++) begin
      chk("R4", "clk_en decode", 32'(ce[c]), 32'(c == 1 || c == 3));
      chk("R4", "rst_rel decode", 32'(rel[c]), 32'(c == 2 || c == 3));
    end

    // R7: nothing pending
    wr(12'h120, 32'h1);
    for (int t = 0; t < 6; t++) begin
      rd(12'h128, d);
      chk("R7", "status with nothing pending", d, 32'h0);
      check_outputs("R7");
      @(negedge clk);
    end

    // Pattern B: scrambled codes, request plus go injected mid-walk
    for (int i = 0; i < N; i++) set_next(i, (i * 7 + 3) % 32);
    check_outputs("R5");
    run_go(1'b1, 5, 9);
    rd(12'h814, d);
    chk("R8", "module 5 keeps code latched at go", d, 32'(tgt_m[5]));
    rd(12'h128, d);
    chk("R8", "mid-walk go ignored", d, 32'h0);
    run_go(1'b0, 0, 0);
    chk("R8", "second walk length", 32'(k), 32'h1);
    check_readback();

    // Pattern C: sparse, first and last modules only
    set_next(N - 1, 3);
    set_next(0, 1);
    run_go(1'b0, 0, 0);
    chk("R6", "sparse walk length", 32'(k), 32'h2);
    chk("R6", "ascending order", 32'(pl[0]), 32'h0);
    check_readback();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule